// File: doc/BRIEF.md
# Amplifier Stage Reset Sequencer

This block sits next to a PWM modulator and controls the active-low reset of a switching power stage. It keeps the stage in its high-impedance state, with reset held low, until three conditions are met: the gate supply has been reported good for a full bootstrap-charge interval, the modulator reports that it is initialised, and the PWM stream it feeds the stage has been measured as switching inside a permitted frequency window. Only then does it release reset.

While the stage is running, the PWM period is checked on every rising edge. An out-of-window period, a missing edge (stuck high or stuck low), or the modulator dropping its ready flag pulls reset low at once and returns the block to waiting. A shutdown request or a loss of supply drives reset low first and keeps the modulator enabled for a short hold time before the PWM is gated off. A three-bit status word reports the current phase.

All limits are parameters: the clock rate in kHz, the charge interval in microseconds, the frequency window in kHz, the number of consecutive good periods needed, the stop hold time and the synchroniser depth.

Top module: `amp_rst_seq`

## Requirements
- R1: While rst_ni is low, the status is off (code 0), the stage reset output is low and the PWM enable is low.
- R2: With supply good and no shutdown request, the block enters charging (code 1) and stays there for exactly CLK_KHZ*CHARGE_US/1000 cycles with stage reset low and PWM enable low, then enters waiting (code 2).
- R3: Supply loss or a shutdown request during charging returns the block to off, and the next charge interval restarts from zero; while shutdown is requested the block stays off.
- R4: In waiting, the PWM enable is high and stage reset is low; the block enters running (code 3, stage reset high) only when the modulator is ready and the last GOOD_PERIODS rising-edge-to-rising-edge periods were all inside the window.
- R5: The window is MIN_PER = ceil(CLK_KHZ/PWM_MAX_KHZ) to MAX_PER = floor(CLK_KHZ/PWM_MIN_KHZ) clock cycles, both ends inclusive (250 to 285 at 100 MHz, 350 to 400 kHz); a period one cycle outside either end is invalid.
- R6: If no rising edge is seen for more than MAX_PER cycles (input stuck high or stuck low), the PWM is treated as invalid.
- R7: In running, an invalid period, a missing edge or a dropped modulator-ready flag returns the block to waiting with stage reset low within the input synchroniser latency plus two cycles.
- R8: A shutdown request or supply loss in waiting or running moves the block to stopping (code 4): stage reset is low while PWM enable stays high for exactly STOP_CYC cycles, after which the block is off with PWM enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Gate supply good flag (asynchronous) |
| mod_ready_i | input | 1 | Modulator initialised flag (asynchronous) |
| shutdown_i | input | 1 | Shutdown request (asynchronous) |
| pwm_i | input | 1 | PWM stream from the modulator, monitored |
| stage_rst_no | output | 1 | Active-low reset to the power stage |
| pwm_en_o | output | 1 | Enable for the modulator's PWM output |
| state_o | output | 3 | Status: 0 off, 1 charging, 2 waiting, 3 running, 4 stopping |

## Verification
The hardest situations to reach are the exact window edges and the switch between valid and invalid streams while running, because an abrupt change of period in the stimulus itself produces a short stray period. The bench PWM generator therefore changes period or level only at the end of a full cycle, so every measured period is exactly one requested value; it steps through 249, 250, 285 and 286 cycles, stuck-high and stuck-low levels, and periods well outside the window. A behavioural model fed with the same inputs predicts the status every cycle, and the length of each charging and stopping interval is measured at the ports.

// File: rtl/amp_rst_seq_pkg.sv
package amp_rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_CHARGE = 3'd1,
    ST_WAIT   = 3'd2,
    ST_RUN    = 3'd3,
    ST_STOP   = 3'd4
  } seq_state_e;

  // bit positions inside the synchronised control vector
  localparam int unsigned IDX_SUP = 0;
  localparam int unsigned IDX_RDY = 1;
  localparam int unsigned IDX_SHD = 2;
  localparam int unsigned IDX_PWM = 3;
  localparam int unsigned CTL_W   = 4;

endpackage

// File: rtl/amp_rst_seq_sync.sv
module amp_rst_seq_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/amp_rst_seq_pwm_mon.sv
module amp_rst_seq_pwm_mon #(
  parameter int unsigned MIN_PER = 250,
  parameter int unsigned MAX_PER = 285,
  parameter int unsigned GOOD_N  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  output logic good_o
);

  localparam int unsigned CW = $clog2(MAX_PER + 2);
  localparam int unsigned GW = $clog2(GOOD_N + 1);
  localparam logic [CW-1:0] CNT_MIN  = CW'(MIN_PER);
  localparam logic [CW-1:0] CNT_MAX  = CW'(MAX_PER);
  localparam logic [CW-1:0] CNT_TMO  = CW'(MAX_PER + 1);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [GW-1:0] GOOD_TOP = GW'(GOOD_N);

  logic          prev_q;
  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic [GW-1:0] good_q;
  logic          rise;
  logic          tmo;
  logic          in_win;

  assign rise   = pwm_i & ~prev_q;
  assign tmo    = (cnt_q == CNT_TMO);
  assign in_win = (cnt_q >= CNT_MIN) && (cnt_q <= CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= CNT_TMO;
      good_q  <= '0;
    end else begin
      prev_q <= pwm_i;
      if (rise) begin
        cnt_q   <= CNT_ONE;
        armed_q <= 1'b1;
        if (armed_q && in_win) begin
          if (good_q != GOOD_TOP) good_q <= good_q + 1'b1;
        end else begin
          good_q <= '0;
        end
      end else if (!tmo) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        // edge overdue: stuck level
        armed_q <= 1'b0;
        good_q  <= '0;
      end
    end
  end

  assign good_o = (good_q == GOOD_TOP);

endmodule

// File: rtl/amp_rst_seq_timer.sv
module amp_rst_seq_timer #(
  parameter int unsigned W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  output logic         done_o
);

  localparam logic [W:0] ONE = (W+1)'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // true in the last cycle of an interval of lim_i cycles
  assign done_o = ({1'b0, cnt_q} + ONE) >= {1'b0, lim_i};

endmodule

// File: rtl/amp_rst_seq_fsm.sv
module amp_rst_seq_fsm
  import amp_rst_seq_pkg::*;
#(
  parameter int unsigned TW         = 17,
  parameter int unsigned CHARGE_CYC = 100000,
  parameter int unsigned STOP_CYC   = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sup_i,
  input  logic          rdy_i,
  input  logic          shd_i,
  input  logic          good_i,
  input  logic          done_i,
  output seq_state_e    state_o,
  output logic          clr_o,
  output logic [TW-1:0] lim_o
);

  localparam logic [TW-1:0] LIM_CHG  = TW'(CHARGE_CYC);
  localparam logic [TW-1:0] LIM_STOP = TW'(STOP_CYC);

  seq_state_e st_q, st_d;
  logic       halt;

  assign halt = !sup_i || shd_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:    if (!halt) st_d = ST_CHARGE;
      ST_CHARGE: begin
        if (halt)        st_d = ST_OFF;
        else if (done_i) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (halt)                st_d = ST_STOP;
        else if (good_i && rdy_i) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (halt)                   st_d = ST_STOP;
        else if (!good_i || !rdy_i) st_d = ST_WAIT;
      end
      ST_STOP:   if (done_i) st_d = ST_OFF;
      default:   st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
  assign clr_o   = (st_d != st_q);
  assign lim_o   = (st_q == ST_STOP) ? LIM_STOP : LIM_CHG;

endmodule

// File: rtl/amp_rst_seq.sv
module amp_rst_seq
  import amp_rst_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ      = 100000,
  parameter int unsigned CHARGE_US    = 1000,
  parameter int unsigned PWM_MIN_KHZ  = 350,
  parameter int unsigned PWM_MAX_KHZ  = 400,
  parameter int unsigned GOOD_PERIODS = 4,
  parameter int unsigned STOP_CYC     = 64,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       mod_ready_i,
  input  logic       shutdown_i,
  input  logic       pwm_i,
  output logic       stage_rst_no,
  output logic       pwm_en_o,
  output logic [2:0] state_o
);

  localparam int unsigned CHARGE_CYC = CLK_KHZ * CHARGE_US / 1000;
  localparam int unsigned MIN_PER    = (CLK_KHZ + PWM_MAX_KHZ - 1) / PWM_MAX_KHZ;
  localparam int unsigned MAX_PER    = CLK_KHZ / PWM_MIN_KHZ;
  localparam int unsigned LONGEST    = (CHARGE_CYC > STOP_CYC) ? CHARGE_CYC : STOP_CYC;
  localparam int unsigned TW         = $clog2(LONGEST + 1);

  logic [CTL_W-1:0] ctl_raw, ctl_s;
  logic             pwm_good;
  logic             tmr_clr, tmr_done;
  logic [TW-1:0]    tmr_lim;
  seq_state_e       st;

  assign ctl_raw[IDX_SUP] = supply_ok_i;
  assign ctl_raw[IDX_RDY] = mod_ready_i;
  assign ctl_raw[IDX_SHD] = shutdown_i;
  assign ctl_raw[IDX_PWM] = pwm_i;

  amp_rst_seq_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  amp_rst_seq_pwm_mon #(
    .MIN_PER(MIN_PER),
    .MAX_PER(MAX_PER),
    .GOOD_N (GOOD_PERIODS)
  ) u_mon (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pwm_i (ctl_s[IDX_PWM]),
    .good_o(pwm_good)
  );

  amp_rst_seq_timer #(.W(TW)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .lim_i (tmr_lim),
    .done_o(tmr_done)
  );

  amp_rst_seq_fsm #(
    .TW        (TW),
    .CHARGE_CYC(CHARGE_CYC),
    .STOP_CYC  (STOP_CYC)
  ) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sup_i  (ctl_s[IDX_SUP]),
    .rdy_i  (ctl_s[IDX_RDY]),
    .shd_i  (ctl_s[IDX_SHD]),
    .good_i (pwm_good),
    .done_i (tmr_done),
    .state_o(st),
    .clr_o  (tmr_clr),
    .lim_o  (tmr_lim)
  );

  assign stage_rst_no = (st == ST_RUN);
  assign pwm_en_o     = (st == ST_WAIT) || (st == ST_RUN) || (st == ST_STOP);
  assign state_o      = st;

endmodule

// File: rtl/amp_rst_seq_chk.sv
module amp_rst_seq_chk
  import amp_rst_seq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stage_rst_no,
  input logic             pwm_en_o,
  input logic [2:0]       state_o,
  input logic             pwm_good,
  input logic [CTL_W-1:0] ctl_s
);

  // R4
  release_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stage_rst_no) |-> ($past(pwm_good) && $past(ctl_s[IDX_RDY])
                             && $past(state_o) == ST_WAIT));

  // R7
  bad_pwm_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RUN && !pwm_good) |=> (state_o != ST_RUN));

  // R8
  halt_to_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == ST_RUN || state_o == ST_WAIT) && ctl_s[IDX_SHD]) |=> (state_o == ST_STOP));

  // R8
  rst_before_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_en_o) |-> ($past(state_o) == ST_STOP && !$past(stage_rst_no)));

  // R2
  enable_after_charge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_en_o) |-> ($past(state_o) == ST_CHARGE));

  // R1
  legal_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4);

endmodule

bind amp_rst_seq amp_rst_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stage_rst_no(stage_rst_no),
  .pwm_en_o    (pwm_en_o),
  .state_o     (state_o),
  .pwm_good    (pwm_good),
  .ctl_s       (ctl_s)
);

// File: tb/tb_amp_rst_seq.sv
module tb_amp_rst_seq;

  localparam int CHG   = 1000;  // 100000 kHz * 10 us / 1000
  localparam int STOPC = 16;
  localparam int MINP  = 250;
  localparam int MAXP  = 285;
  localparam int GOODN = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       supply_ok_i = 1'b0;
  logic       mod_ready_i = 1'b0;
  logic       shutdown_i = 1'b0;
  logic       pwm_i = 1'b0;
  logic       stage_rst_no;
  logic       pwm_en_o;
  logic [2:0] state_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  amp_rst_seq #(
    .CLK_KHZ     (100000),
    .CHARGE_US   (10),
    .PWM_MIN_KHZ (350),
    .PWM_MAX_KHZ (400),
    .GOOD_PERIODS(GOODN),
    .STOP_CYC    (STOPC),
    .SYNC_STAGES (2)
  ) dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .mod_ready_i (mod_ready_i),
    .shutdown_i  (shutdown_i),
    .pwm_i       (pwm_i),
    .stage_rst_no(stage_rst_no),
    .pwm_en_o    (pwm_en_o),
    .state_o     (state_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- PWM generator: changes only at period boundaries
  int per_next = 0;
  int per_cur  = 0;
  int ph       = 0;
  bit lvl      = 1'b0;

  always @(negedge clk) begin
    if (per_cur == 0) begin
      if (per_next != 0) begin
        per_cur = per_next;
        ph      = 0;
        pwm_i   = 1'b1;
      end else begin
        pwm_i = lvl;
      end
    end else if (ph >= per_cur - 1) begin
      ph      = 0;
      per_cur = per_next;
      pwm_i   = (per_cur == 0) ? lvl : 1'b1;
    end else begin
      ph++;
      pwm_i = (ph < per_cur / 2);
    end
  end

  // ---------------- behavioural reference model
  int m_st = 0, m_tmr = 0, m_gcnt = 0, m_n = 0, m_last = 0;
  bit m_have = 0;
  bit h_sup[3], h_rdy[3], h_shd[3], h_pwm[3];

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_st = 0; m_tmr = 0; m_gcnt = 0; m_n = 0; m_last = 0; m_have = 0;
      for (int i = 0; i < 3; i++) begin
        h_sup[i] = 0; h_rdy[i] = 0; h_shd[i] = 0; h_pwm[i] = 0;
      end
    end else begin
      bit sup, rdy, shd, rise, good, done, halt;
      int nst, lim;
      m_n++;
      sup  = h_sup[1]; rdy = h_rdy[1]; shd = h_shd[1];
      rise = h_pwm[1] && !h_pwm[2];
      good = (m_gcnt == GOODN);
      lim  = (m_st == 4) ? STOPC : CHG;
      done = (m_tmr + 1 >= lim);
      halt = !sup || shd;
      nst  = m_st;
      case (m_st)
        0: if (!halt) nst = 1;
        1: if (halt) nst = 0; else if (done) nst = 2;
        2: if (halt) nst = 4; else if (good && rdy) nst = 3;
        3: if (halt) nst = 4; else if (!good || !rdy) nst = 2;
        4: if (done) nst = 0;
        default: nst = 0;
      endcase
      m_tmr = (nst != m_st) ? 0 : m_tmr + 1;
      m_st  = nst;
      if (rise) begin
        if (m_have && (m_n - m_last) >= MINP && (m_n - m_last) <= MAXP)
          m_gcnt = (m_gcnt < GOODN) ? m_gcnt + 1 : GOODN;
        else
          m_gcnt = 0;
        m_last = m_n;
        m_have = 1;
      end else if (m_have && (m_n - m_last) > MAXP) begin
        m_gcnt = 0;
      end
      h_sup[2] = h_sup[1]; h_sup[1] = h_sup[0]; h_sup[0] = supply_ok_i;
      h_rdy[2] = h_rdy[1]; h_rdy[1] = h_rdy[0]; h_rdy[0] = mod_ready_i;
      h_shd[2] = h_shd[1]; h_shd[1] = h_shd[0]; h_shd[0] = shutdown_i;
      h_pwm[2] = h_pwm[1]; h_pwm[1] = h_pwm[0]; h_pwm[0] = pwm_i;
    end
  end

  function automatic string tag_of(input int s);
    case (s)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  // ---------------- per-cycle compare and interval lengths
  int prev_st = 0;
  int run_len = 0;

  always @(negedge clk) begin
    string t;
    t = tag_of(m_st);
    chk(state_o === 3'(m_st), {t, " status vs model"}, int'(state_o), m_st);
    chk(stage_rst_no === (m_st == 3), {t, " stage reset vs model"}, int'(stage_rst_no), int'(m_st == 3));
    chk(pwm_en_o === (m_st >= 2), {t, " pwm enable vs model"}, int'(pwm_en_o), int'(m_st >= 2));
    if (int'(state_o) == prev_st) begin
      run_len++;
    end else begin
      if (prev_st == 1 && state_o == 3'd2)
        chk(run_len == CHG, "R2 charge interval length", run_len, CHG);
      if (prev_st == 4)
        chk(run_len == STOPC, "R8 stop hold length", run_len, STOPC);
      run_len = 1;
      prev_st = int'(state_o);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_st(input int s, input string tag);
    chk(int'(state_o) == s, {tag, " status"}, int'(state_o), s);
    chk(stage_rst_no == (s == 3), {tag, " stage reset"}, int'(stage_rst_no), int'(s == 3));
    chk(pwm_en_o == (s >= 2), {tag, " pwm enable"}, int'(pwm_en_o), int'(s >= 2));
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    cyc(5);
    exp_st(0, "R1");
    rst_ni = 1'b1;
    cyc(3);
    exp_st(0, "R1");

    // charge start, abort, restart
    supply_ok_i = 1'b1;
    cyc(10);
    exp_st(1, "R2");
    cyc(300);
    supply_ok_i = 1'b0;
    cyc(5);
    exp_st(0, "R3");
    supply_ok_i = 1'b1;
    cyc(900);
    exp_st(1, "R3");
    cyc(200);
    exp_st(2, "R2");

    // waiting without PWM
    cyc(500);
    exp_st(2, "R4");

    // too slow, too fast, modulator not ready
    mod_ready_i = 1'b1;
    per_next = 300;
    cyc(2400);
    exp_st(2, "R5");
    per_next = 240;
    cyc(2400);
    exp_st(2, "R5");
    mod_ready_i = 1'b0;
    per_next = 270;
    cyc(2400);
    exp_st(2, "R4");
    mod_ready_i = 1'b1;
    cyc(20);
    exp_st(3, "R4");

    // window edges
    per_next = 250;
    cyc(2000);
    exp_st(3, "R5");
    per_next = 285;
    cyc(2000);
    exp_st(3, "R5");
    per_next = 286;
    cyc(860);
    exp_st(2, "R5");
    per_next = 285;
    cyc(1500);
    exp_st(3, "R5");
    per_next = 249;
    cyc(1000);
    exp_st(2, "R5");
    per_next = 270;
    cyc(1500);
    exp_st(3, "R7");

    // stuck high, stuck low
    lvl = 1'b1;
    per_next = 0;
    cyc(700);
    exp_st(2, "R6");
    per_next = 270;
    cyc(1500);
    exp_st(3, "R6");
    lvl = 1'b0;
    per_next = 0;
    cyc(700);
    exp_st(2, "R6");
    per_next = 270;
    cyc(1500);
    exp_st(3, "R7");

    // modulator drops ready
    mod_ready_i = 1'b0;
    cyc(10);
    exp_st(2, "R7");
    mod_ready_i = 1'b1;
    cyc(10);
    exp_st(3, "R7");

    // shutdown from running
    shutdown_i = 1'b1;
    cyc(5);
    exp_st(4, "R8");
    cyc(30);
    exp_st(0, "R8");
    cyc(100);
    exp_st(0, "R3");
    shutdown_i = 1'b0;
    cyc(1100);
    exp_st(3, "R4");

    // supply loss from running
    supply_ok_i = 1'b0;
    cyc(5);
    exp_st(4, "R8");
    cyc(30);
    exp_st(0, "R8");

    cyc(10);
    summary();
    $finish;
  end

endmodule